// File: doc/BRIEF.md
# Class-D Audio PWM Modulator with Dead Time

This block drives a half-bridge class-D output stage from a stream of 12-bit audio samples. A free-running timebase counts from zero up to a fixed terminal value and then wraps. A single raw pulse-width signal is high from the start of each period until the counter meets the active duty value. Two gate-drive outputs are derived from that raw signal. Each one has its own turn-on delay, so the high-side and low-side switches never conduct together.

In the last cycle of every period the block raises a one-cycle conversion request toward an external sample converter. The converter answers with a sample and a one-cycle valid flag. The block keeps the upper bits of that sample (a right shift) as the next duty value. The value waits in a staging register and becomes active only at the next period start, so a duty change never cuts into a running period. Duty values at or above the terminal count give a fully-on output. A duty value of zero gives a fully-off output.

Top module: `classd_modulator`

## Requirements
- R1: The timebase counter runs through 0..120 and then wraps to 0, one step per clock. `conv_start` is therefore high exactly once every 121 clocks, and the counter reads 0 in the clock after each pulse.
- R2: The raw signal is high while the counter is below the active duty value and low from the counter value equal to it until the period ends. With duty D in 6..119, `gate_hi` is high for D-5 clocks of each period.
- R3: A new duty value is held in a staging register. It is copied to the active duty only when the counter wraps to 0, so the pulse widths of a running period do not change.
- R4: While `rst_n` is low, `gate_hi`, `gate_lo` and `conv_start` are low. Both duty registers then hold 60, so the first period after reset has a 50% raw duty (55 high-side clocks, 54 low-side clocks per period).
- R5: `conv_start` is a single-clock pulse, raised in the clock where the counter equals 120.
- R6: When `smp_valid` is high, bits [11:5] of `smp_data` (the sample shifted right by 5) become the staged duty value. When `smp_valid` is low, `smp_data` has no effect on the outputs.
- R7: `gate_hi` follows the raw signal, but it rises only after the raw signal has been high for 5 clocks. It falls in the same clock as the raw signal.
- R8: `gate_lo` is the inverse of the raw signal, but it rises only after the raw signal has been low for 7 clocks. It falls in the same clock as the raw signal rises. `gate_hi` and `gate_lo` are never high together.
- R9: An active duty of 120 or more keeps the raw signal high for the whole period: `gate_hi` stays high and `gate_lo` stays low in steady state. An active duty of 0 gives the opposite.
- R10: A raw high pulse shorter than 5 clocks never appears on `gate_hi`, and a raw low gap shorter than 7 clocks never appears on `gate_lo`. For example, duty 3 gives no `gate_hi` pulse, and duty 118 gives no `gate_lo` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock; the counter steps once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| smp_valid | input | 1 | Qualifies `smp_data` for one clock |
| smp_data | input | 12 | Unsigned audio sample from the converter |
| conv_start | output | 1 | One-clock request for the next conversion, at period end |
| gate_hi | output | 1 | High-side gate drive, with turn-on delay |
| gate_lo | output | 1 | Low-side gate drive, with turn-on delay |

## Verification
The assertions assume that `rst_n` is released away from the active clock edge. They also assume that `smp_valid` and `smp_data` are stable around each rising edge. The bench changes both only at falling edges. The assertions make no assumption about when samples arrive. The random phase therefore sends valid pulses at arbitrary counter phases, including several in one period and some in the wrap cycle, with sample values across the full 12-bit range. The directed cases steer the staged duty to 0, 3, 60, 100, 118 and 127. This reaches the fully-off, fully-on and pulse-suppression corners.

// File: rtl/classd_pkg.sv
package classd_pkg;

  // Default geometry of the modulator
  localparam int DEF_PERIOD    = 120;
  localparam int DEF_SAMPLE_W  = 12;
  localparam int DEF_SHIFT     = 5;
  localparam int DEF_RESET_CMP = 60;
  localparam int DEF_RISE_DLY  = 5;
  localparam int DEF_FALL_DLY  = 7;

  // Output legs of the half bridge
  typedef enum logic {
    LEG_HIGH = 1'b0,
    LEG_LOW  = 1'b1
  } leg_e;

  localparam int NUM_LEGS = 2;

endpackage

// File: rtl/classd_timebase.sv
module classd_timebase #(
  parameter int PERIOD = 120,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == CNT_W'(PERIOD));
    if (at_top) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = at_top;

endmodule

// File: rtl/classd_duty.sv
module classd_duty #(
  parameter int PERIOD    = 120,
  parameter int SAMPLE_W  = 12,
  parameter int SHIFT     = 5,
  parameter int RESET_CMP = 60,
  parameter int CNT_W     = 7,
  parameter int CMP_W     = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                load,
  output logic [CMP_W-1:0]    act_cmp_o,
  output logic                raw_o
);

  localparam int CMX_W = (CNT_W > CMP_W) ? CNT_W : CMP_W;

  logic [CMP_W-1:0] shadow_q, shadow_d;
  logic [CMP_W-1:0] active_q, active_d;
  logic             shadow_en, active_en;
  logic             raw_q, raw_d;
  logic [CMX_W-1:0] cnt_x, act_x;
  logic             full_on, zero_duty;

  // Staging register: scaled sample, qualified by the valid strobe
  always_comb begin
    shadow_en = smp_vld;
    shadow_d  = smp[SAMPLE_W-1:SHIFT];
  end

  // Active register: refreshed only as the counter wraps to zero
  always_comb begin
    active_en = load;
    active_d  = shadow_q;
  end

  // Raw pulse: high from period start until the counter meets the duty
  always_comb begin
    cnt_x     = CMX_W'(cnt);
    act_x     = CMX_W'(active_q);
    full_on   = (act_x >= CMX_W'(PERIOD));
    zero_duty = (active_q == '0);
    raw_d     = !zero_duty && (full_on || (cnt_x < act_x));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= CMP_W'(RESET_CMP);
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= CMP_W'(RESET_CMP);
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
    end
  end

  assign act_cmp_o = active_q;
  assign raw_o     = raw_q;

endmodule

// File: rtl/classd_edge_delay.sv
module classd_edge_delay #(
  parameter int DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic out_o
);

  localparam int RUN_W = $clog2(DLY + 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             run_full;

  // Count how long the input level has been high, saturating at DLY
  always_comb begin
    run_full = (run_q == RUN_W'(DLY));
    if (!lvl_i) begin
      run_d = '0;
    end else if (!run_full) begin
      run_d = run_q + RUN_W'(1);
    end else begin
      run_d = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

  // Released only once the level has lasted the full delay;
  // a shorter pulse never reaches the output
  assign out_o = lvl_i && run_full;

endmodule

// File: rtl/classd_modulator.sv
module classd_modulator
  import classd_pkg::*;
#(
  parameter int PERIOD    = DEF_PERIOD,
  parameter int SAMPLE_W  = DEF_SAMPLE_W,
  parameter int SHIFT     = DEF_SHIFT,
  parameter int RESET_CMP = DEF_RESET_CMP,
  parameter int RISE_DLY  = DEF_RISE_DLY,
  parameter int FALL_DLY  = DEF_FALL_DLY
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                conv_start,
  output logic                gate_hi,
  output logic                gate_lo
);

  localparam int CNT_W = $clog2(PERIOD + 1);
  localparam int CMP_W = SAMPLE_W - SHIFT;

  logic [CNT_W-1:0]    tb_cnt;
  logic                tb_wrap;
  logic [CMP_W-1:0]    act_cmp;
  logic                pwm_raw;
  logic [NUM_LEGS-1:0] leg_out;

  classd_timebase #(
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W)
  ) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_o  (tb_cnt),
    .wrap_o (tb_wrap)
  );

  classd_duty #(
    .PERIOD    (PERIOD),
    .SAMPLE_W  (SAMPLE_W),
    .SHIFT     (SHIFT),
    .RESET_CMP (RESET_CMP),
    .CNT_W     (CNT_W),
    .CMP_W     (CMP_W)
  ) u_duty (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_valid),
    .smp       (smp_data),
    .cnt       (tb_cnt),
    .load      (tb_wrap),
    .act_cmp_o (act_cmp),
    .raw_o     (pwm_raw)
  );

  // One delay unit per leg: the high leg sees the raw level, the low leg its inverse
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    localparam int LEG_DLY = (g == int'(LEG_HIGH)) ? RISE_DLY : FALL_DLY;
    logic leg_lvl;
    assign leg_lvl = (g == int'(LEG_HIGH)) ? pwm_raw : !pwm_raw;

    classd_edge_delay #(
      .DLY (LEG_DLY)
    ) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (leg_lvl),
      .out_o (leg_out[g])
    );
  end

  assign conv_start = tb_wrap;
  assign gate_hi    = leg_out[int'(LEG_HIGH)];
  assign gate_lo    = leg_out[int'(LEG_LOW)];

endmodule

// File: rtl/classd_modulator_chk.sv
module classd_modulator_chk #(
  parameter int PERIOD = 120,
  parameter int CNT_W  = 7,
  parameter int CMP_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_start,
  input logic             gate_hi,
  input logic             gate_lo,
  input logic [CNT_W-1:0] cnt,
  input logic [CMP_W-1:0] act_cmp,
  input logic             raw
);

  localparam int CMX_W = (CNT_W > CMP_W) ? CNT_W : CMP_W;

  logic act_full;
  assign act_full = (CMX_W'(act_cmp) >= CMX_W'(PERIOD));

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (cnt == '0)); // R1

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R5

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(act_cmp)); // R3

  AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != '0) && act_full) |-> raw); // R9

  AST_FULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != '0) && (act_cmp == '0)) |-> !raw); // R9

  AST_HI_TURN_ON_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |=> !gate_hi); // R7

  AST_LO_TURN_ON_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw) |=> !gate_lo); // R8

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R8

endmodule

bind classd_modulator classd_modulator_chk #(
  .PERIOD (PERIOD),
  .CNT_W  (CNT_W),
  .CMP_W  (CMP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo),
  .cnt        (tb_cnt),
  .act_cmp    (act_cmp),
  .raw        (pwm_raw)
);

// File: tb/sim_classd_modulator.sv
`timescale 1ns/1ps
module sim_classd_modulator;

  localparam int PER = 120;
  localparam int RD  = 5;
  localparam int FD  = 7;
  localparam int SH  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [11:0] in_smp = '0;
  logic        conv_start, gate_hi, gate_lo;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_n = 0;
  bit done = 1'b0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;

  classd_modulator u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (in_vld),
    .smp_data   (in_smp),
    .conv_start (conv_start),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo)
  );

  function automatic bit exp_raw(int c, int cmp);
    return (cmp != 0) && ((cmp >= PER) || (c < cmp));
  endfunction

  // Steady-state count of clocks per period that a leg is high
  function automatic int leg_count(int cmp, bit hi_leg);
    int total = 0;
    int dly = hi_leg ? RD : FD;
    for (int c = 0; c <= PER; c++) begin
      bit ok = 1'b1;
      for (int k = 0; k <= dly; k++) begin
        int pos = (c - k + 2 * (PER + 1)) % (PER + 1);
        bit rq = exp_raw((pos + PER) % (PER + 1), cmp);
        if ((hi_leg ? rq : !rq) == 1'b0) ok = 1'b0;
      end
      if (ok) total++;
    end
    return total;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Cycle model of the requirements
  int m_cnt, m_sh, m_act, m_hr, m_lr;
  bit m_raw;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sh = 60; m_act = 60; m_hr = 0; m_lr = 0; m_raw = 1'b0;
    end else begin
      bit nraw;
      nraw = exp_raw(m_cnt, m_act);
      if (m_raw) m_hr = (m_hr < RD) ? m_hr + 1 : RD; else m_hr = 0;
      if (!m_raw) m_lr = (m_lr < FD) ? m_lr + 1 : FD; else m_lr = 0;
      m_raw = nraw;
      if (m_cnt == PER) begin
        m_act = m_sh;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
      if (in_vld) m_sh = int'(in_smp) >> SH;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      chk("R7 gate_hi per-cycle", int'(gate_hi), int'(m_raw && (m_hr == RD)));
      chk("R8 gate_lo per-cycle", int'(gate_lo), int'(!m_raw && (m_lr == FD)));
      chk("R5 conv_start per-cycle", int'(conv_start), int'(m_cnt == PER));
      chk("R8 no overlap", int'(gate_hi && gate_lo), 0);
    end
  end

  task automatic load(int v);
    @(negedge clk);
    in_vld = 1'b1;
    in_smp = 12'(v);
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  // Align to a period end, then count one full period; optional mid-period sample
  task automatic measure(output int hs, output int ls, output int soc,
                         input int inj_at, input int inj_val);
    int guard = 0;
    hs = 0; ls = 0; soc = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!conv_start && guard < 300);
    for (int i = 0; i <= PER; i++) begin
      @(negedge clk);
      hs += int'(gate_hi);
      ls += int'(gate_lo);
      soc += int'(conv_start);
      if (i == inj_at) begin
        in_vld = 1'b1;
        in_smp = 12'(inj_val);
      end else begin
        in_vld = 1'b0;
      end
    end
  endtask

  task automatic check_duty(string req, int cmp);
    int hs, ls, soc;
    measure(hs, ls, soc, -1, 0);
    measure(hs, ls, soc, -1, 0);
    chk({req, " gate_hi clocks"}, hs, leg_count(cmp, 1'b1));
    chk({req, " gate_lo clocks"}, ls, leg_count(cmp, 1'b0));
    chk("R1 one request per period", soc, 1);
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc_n);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hs, ls, soc;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk("R4 reset gate_hi", int'(gate_hi), 0);
    chk("R4 reset gate_lo", int'(gate_lo), 0);
    chk("R4 reset conv_start", int'(conv_start), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R4 / R2: first period after reset uses the reset duty of 60
    measure(hs, ls, soc, -1, 0);
    chk("R4 reset duty gate_hi", hs, leg_count(60, 1'b1));
    chk("R4 reset duty gate_lo", ls, leg_count(60, 1'b0));
    chk("R1 request spacing", soc, 1);

    // R3: sample mid-period leaves this period alone; R2/R6 next period uses 3200>>5=100
    measure(hs, ls, soc, 30, 3200);
    chk("R3 mid-period update held", hs, leg_count(60, 1'b1));
    measure(hs, ls, soc, -1, 0);
    chk("R2 duty 100 gate_hi", hs, leg_count(100, 1'b1));
    chk("R6 shifted sample gate_lo", ls, leg_count(100, 1'b0));

    // R6: data without valid is ignored
    @(negedge clk);
    in_smp = 12'd0;
    measure(hs, ls, soc, -1, 0);
    chk("R6 ignored without valid", hs, leg_count(100, 1'b1));

    load(4095); check_duty("R9 full-on", 127);
    load(17);   check_duty("R9 full-off", 0);
    load(100);  check_duty("R10 short high pulse", 3);
    load(3781); check_duty("R10 short low gap", 118);
    load(1920); check_duty("R2 duty 60", 60);

    // Random samples at arbitrary phases
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      in_vld = (($urandom % 8) == 0);
      in_smp = 12'($urandom % 4096);
    end
    @(negedge clk);
    in_vld = 1'b0;

    // Mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R4 async reset gate_hi", int'(gate_hi), 0);
    chk("R4 async reset gate_lo", int'(gate_lo), 0);
    chk("R4 async reset conv_start", int'(conv_start), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    measure(hs, ls, soc, -1, 0);
    chk("R4 duty restored gate_hi", hs, leg_count(60, 1'b1));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule